// File: doc/BRIEF.md
# Dual-Channel Sample Output Formatter

This block is the digital output stage of a two-channel sampling converter. On every rising edge of the sample clock it takes one word from each channel and passes both words through a fixed-latency register pipeline. At the far end of that pipeline each word is put into the number format chosen by a format input, either offset binary or two's complement. The two formatted words then go out on two output ports. A route input decides whether each port carries its own channel or the other one.

When the route input is tied to the sample clock, one port carries channel A while the clock is high and channel B while the clock is low. That port then delivers both channels at twice the sample rate. Each port has an active-high disable, so the unused port can be forced quiet. A disabled port drives all zeros.

The pipeline resets to the mid-scale code. The first outputs after reset are therefore well defined.

Top module: `dual_sample_formatter`

## Requirements
- R1: A word that sits on a channel input at rising clock edge n appears, formatted, on the outputs just after rising edge n+6. That is seven register stages (default `LATENCY` = 7) counting the capture edge, and the outputs change only after a rising edge.
- R2: While reset is low, and for the first six rising edges after it is released, each channel's delayed word is mid-scale (MSB set, all other bits zero). With the format input low the ports show that code; with it high the ports show all zeros.
- R3: With the format input low, a port shows the delayed word unchanged (offset binary).
- R4: With the format input high, a port shows the delayed word with its MSB (bit SAMPLE_W-1) inverted (two's complement). Code 0 becomes MSB-only and all-ones becomes MSB-clear.
- R5: The format input acts on the word already at the end of the pipeline. A change on it shows on the ports in the same cycle, without waiting for the pipeline.
- R6: With the route input high, port A carries channel A and port B carries channel B.
- R7: With the route input low, port A carries channel B and port B carries channel A.
- R8: With the route input tied to the clock, port A shows channel A while the clock is high and channel B while the clock is low. Both samples belong to the same pipeline slot.
- R9: While the port A disable is high, port A drives all zeros and port B is unaffected.
- R10: While the port B disable is high, port B drives all zeros and port A is unaffected.
- R11: A port disable never stalls a channel pipeline. When a port is enabled again, it shows at once the word that R1 timing calls for.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_a_i | input | SAMPLE_W | Channel A sample, offset binary |
| chan_b_i | input | SAMPLE_W | Channel B sample, offset binary |
| twos_i | input | 1 | Output format: 0 offset binary, 1 two's complement |
| route_i | input | 1 | 1 straight, 0 swapped; may be tied to clk_i |
| off_a_i | input | 1 | Port A disable, active high |
| off_b_i | input | 1 | Port B disable, active high |
| out_a_o | output | SAMPLE_W | Port A data |
| out_b_o | output | SAMPLE_W | Port B data |

## Verification
The hardest case to reach from the ports is interleaving. Here the route input is the clock itself, and port A must show two different channels within one pipeline slot. The bench drives the route input from the clock through a mode flag. It then samples port A in the middle of both the high and the low clock phase, and compares the two values with the channel A and channel B words that were launched seven edges earlier.

Distinct ramps on the two channels mean that a swapped, stale or stalled word can never match by accident. Disable stretches in the middle of the run show that the pipelines keep moving while a port is quiet.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

   // encoder implementation variants
   typedef enum int unsigned {
      ENC_MSB_FLIP = 0,
      ENC_ADD_HALF = 1
   } enc_impl_e;

   // number of converter channels handled by the block
   localparam int unsigned NUM_CHAN = 2;

   function automatic int unsigned chan_a_idx();
      return 0;
   endfunction

   function automatic int unsigned chan_b_idx();
      return 1;
   endfunction

endpackage

// File: rtl/dsf_delay_line.sv
module dsf_delay_line #(
   parameter int unsigned WIDTH = 14,
   parameter int unsigned DEPTH = 7,
   parameter logic [WIDTH-1:0] INIT = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("dsf_delay_line: WIDTH must be at least 1");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("dsf_delay_line: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic [WIDTH-1:0] stage_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            stage_q <= INIT;
         end else begin
            stage_q <= d_i;
         end
      end

      assign q_o = stage_q;
   end else begin : g_chain
      logic [DEPTH-1:0][WIDTH-1:0] stage_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            stage_q <= {DEPTH{INIT}};
         end else begin
            stage_q <= {stage_q[DEPTH-2:0], d_i};
         end
      end

      assign q_o = stage_q[DEPTH-1];
   end

endmodule

// File: rtl/dsf_encoder.sv
module dsf_encoder #(
   parameter int unsigned WIDTH = 14,
   parameter dsf_pkg::enc_impl_e IMPL = dsf_pkg::ENC_MSB_FLIP
) (
   input  logic             twos_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   localparam logic [WIDTH-1:0] HALF = {1'b1, {(WIDTH-1){1'b0}}};

   if (WIDTH < 2) begin : g_bad_width
      $error("dsf_encoder: WIDTH must be at least 2");
   end

   if (IMPL == dsf_pkg::ENC_MSB_FLIP) begin : g_flip
      assign q_o = {d_i[WIDTH-1] ^ twos_i, d_i[WIDTH-2:0]};
   end else begin : g_add
      // adding half scale modulo 2^WIDTH is the same as flipping the MSB
      logic [WIDTH-1:0] shifted;
      assign shifted = d_i + HALF;
      assign q_o     = twos_i ? shifted : d_i;
   end

endmodule

// File: rtl/dsf_port_mux.sv
module dsf_port_mux #(
   parameter int unsigned WIDTH = 14
) (
   input  logic             route_i,
   input  logic [WIDTH-1:0] own_a_i,
   input  logic [WIDTH-1:0] own_b_i,
   input  logic             off_a_i,
   input  logic             off_b_i,
   output logic [WIDTH-1:0] out_a_o,
   output logic [WIDTH-1:0] out_b_o
);

   logic [WIDTH-1:0] pick_a;
   logic [WIDTH-1:0] pick_b;

   always_comb begin
      if (route_i) begin
         pick_a = own_a_i;
         pick_b = own_b_i;
      end else begin
         pick_a = own_b_i;
         pick_b = own_a_i;
      end
   end

   assign out_a_o = off_a_i ? '0 : pick_a;
   assign out_b_o = off_b_i ? '0 : pick_b;

endmodule

// File: rtl/dual_sample_formatter.sv
module dual_sample_formatter #(
   parameter int unsigned SAMPLE_W = 14,
   parameter int unsigned LATENCY  = 7,
   parameter dsf_pkg::enc_impl_e ENC_IMPL = dsf_pkg::ENC_MSB_FLIP
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [SAMPLE_W-1:0] chan_a_i,
   input  logic [SAMPLE_W-1:0] chan_b_i,
   input  logic                twos_i,
   input  logic                route_i,
   input  logic                off_a_i,
   input  logic                off_b_i,
   output logic [SAMPLE_W-1:0] out_a_o,
   output logic [SAMPLE_W-1:0] out_b_o
);

   localparam int unsigned NCH = dsf_pkg::NUM_CHAN;
   localparam logic [SAMPLE_W-1:0] MID_CODE = {1'b1, {(SAMPLE_W-1){1'b0}}};

   if (SAMPLE_W < 2) begin : g_bad_width
      $error("dual_sample_formatter: SAMPLE_W must be at least 2");
   end
   if (LATENCY < 1) begin : g_bad_latency
      $error("dual_sample_formatter: LATENCY must be at least 1");
   end

   logic [SAMPLE_W-1:0] raw   [NCH];
   logic [SAMPLE_W-1:0] tail  [NCH];
   logic [SAMPLE_W-1:0] coded [NCH];
   logic [SAMPLE_W-1:0] tail_a;
   logic [SAMPLE_W-1:0] tail_b;

   assign raw[dsf_pkg::chan_a_idx()] = chan_a_i;
   assign raw[dsf_pkg::chan_b_idx()] = chan_b_i;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      dsf_delay_line #(
         .WIDTH (SAMPLE_W),
         .DEPTH (LATENCY),
         .INIT  (MID_CODE)
      ) i_delay (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .d_i    (raw[ch]),
         .q_o    (tail[ch])
      );

      dsf_encoder #(
         .WIDTH (SAMPLE_W),
         .IMPL  (ENC_IMPL)
      ) i_enc (
         .twos_i (twos_i),
         .d_i    (tail[ch]),
         .q_o    (coded[ch])
      );
   end

   assign tail_a = tail[dsf_pkg::chan_a_idx()];
   assign tail_b = tail[dsf_pkg::chan_b_idx()];

   dsf_port_mux #(
      .WIDTH (SAMPLE_W)
   ) i_mux (
      .route_i (route_i),
      .own_a_i (coded[dsf_pkg::chan_a_idx()]),
      .own_b_i (coded[dsf_pkg::chan_b_idx()]),
      .off_a_i (off_a_i),
      .off_b_i (off_b_i),
      .out_a_o (out_a_o),
      .out_b_o (out_b_o)
   );

endmodule

// File: rtl/dsf_checker.sv
module dsf_checker #(
   parameter int unsigned SAMPLE_W = 14,
   parameter int unsigned LATENCY  = 7
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic [SAMPLE_W-1:0] chan_a_i,
   input logic [SAMPLE_W-1:0] chan_b_i,
   input logic                twos_i,
   input logic                route_i,
   input logic                off_a_i,
   input logic                off_b_i,
   input logic [SAMPLE_W-1:0] out_a_o,
   input logic [SAMPLE_W-1:0] out_b_o,
   input logic [SAMPLE_W-1:0] tail_a_i,
   input logic [SAMPLE_W-1:0] tail_b_i
);

   localparam logic [SAMPLE_W-1:0] MID = {1'b1, {(SAMPLE_W-1){1'b0}}};

   // independent window of past inputs, one slot per pipeline stage
   logic [SAMPLE_W-1:0] hist_a [LATENCY];
   logic [SAMPLE_W-1:0] hist_b [LATENCY];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < LATENCY; i++) begin
            hist_a[i] <= MID;
            hist_b[i] <= MID;
         end
      end else begin
         for (int i = LATENCY - 1; i > 0; i--) begin
            hist_a[i] <= hist_a[i-1];
            hist_b[i] <= hist_b[i-1];
         end
         hist_a[0] <= chan_a_i;
         hist_b[0] <= chan_b_i;
      end
   end

   function automatic logic [SAMPLE_W-1:0] fmt(input logic [SAMPLE_W-1:0] w, input logic t);
      return t ? (w ^ MID) : w;
   endfunction

   assert_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tail_a_i == hist_a[LATENCY-1] && tail_b_i == hist_b[LATENCY-1]);

   assert_reset_mid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> (tail_a_i == MID && tail_b_i == MID));

   assert_offset_bin_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!twos_i && route_i && !off_a_i) |-> out_a_o == tail_a_i);

   assert_twos_comp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (twos_i && route_i && !off_a_i) |-> out_a_o == (tail_a_i ^ MID));

   assert_straight_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (route_i && !off_b_i) |-> out_b_o == fmt(tail_b_i, twos_i));

   assert_swapped_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!route_i && !off_a_i && !off_b_i) |->
         (out_a_o == fmt(tail_b_i, twos_i) && out_b_o == fmt(tail_a_i, twos_i)));

   assert_quiet_a_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      off_a_i |-> out_a_o == '0);

   assert_quiet_b_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      off_b_i |-> out_b_o == '0);

endmodule

bind dual_sample_formatter dsf_checker #(
   .SAMPLE_W (SAMPLE_W),
   .LATENCY  (LATENCY)
) i_dsf_checker (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .chan_a_i (chan_a_i),
   .chan_b_i (chan_b_i),
   .twos_i   (twos_i),
   .route_i  (route_i),
   .off_a_i  (off_a_i),
   .off_b_i  (off_b_i),
   .out_a_o  (out_a_o),
   .out_b_o  (out_b_o),
   .tail_a_i (tail_a),
   .tail_b_i (tail_b)
);

// File: tb/test_dual_sample_formatter.sv
`timescale 1ns/1ps
module test_dual_sample_formatter;

   localparam int W   = 14;
   localparam int LAT = 7;
   localparam logic [W-1:0] MID  = 14'h2000;
   localparam logic [W-1:0] FULL = 14'h3FFF;

   // vector: {twos, mode[1:0] (0 swap, 1 straight, 2 clock-tied), off_a, off_b}
   localparam int NVEC = 10;
   localparam logic [4:0] VEC [NVEC] = '{
      5'b0_01_0_0, 5'b1_01_0_0, 5'b0_00_0_0, 5'b1_00_0_0, 5'b0_10_0_1,
      5'b1_10_0_1, 5'b0_01_1_0, 5'b0_01_0_1, 5'b1_00_1_1, 5'b0_01_0_0
   };

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic         rst_n;
   logic [W-1:0] chan_a, chan_b;
   logic         twos, route_q, ilv, off_a, off_b;
   logic         route;
   logic [W-1:0] out_a, out_b;

   assign route = ilv ? clk : route_q;

   dual_sample_formatter #(.SAMPLE_W(W), .LATENCY(LAT)) i_dual_sample_formatter (
      .clk_i(clk), .rst_ni(rst_n), .chan_a_i(chan_a), .chan_b_i(chan_b),
      .twos_i(twos), .route_i(route), .off_a_i(off_a), .off_b_i(off_b),
      .out_a_o(out_a), .out_b_o(out_b)
   );

   logic [W-1:0] qa [LAT];
   logic [W-1:0] qb [LAT];
   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;
   logic [W-1:0] ramp_a = 14'h0000;
   logic [W-1:0] ramp_b = 14'h3FF0;

   function automatic logic [W-1:0] enc(input logic [W-1:0] w, input logic t);
      return t ? (w ^ MID) : w;
   endfunction

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < LAT; i++) begin
         qa[i] = MID;
         qb[i] = MID;
      end
   endtask

   task automatic push(input logic [W-1:0] a, input logic [W-1:0] b);
      chan_a = a;
      chan_b = b;
      for (int i = LAT - 1; i > 0; i--) begin
         qa[i] = qa[i-1];
         qb[i] = qb[i-1];
      end
      qa[0] = a;
      qb[0] = b;
   endtask

   // check both ports mid high phase, launch next words, then check low phase if clock-tied
   task automatic step(input string ta, input string tb, input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W-1:0] ea, eb;
      @(posedge clk);
      #2;
      if (ilv || route_q) begin
         ea = enc(qa[LAT-1], twos);
         eb = enc(qb[LAT-1], twos);
      end else begin
         ea = enc(qb[LAT-1], twos);
         eb = enc(qa[LAT-1], twos);
      end
      chk(ta, out_a, off_a ? '0 : ea);
      chk(tb, out_b, off_b ? '0 : eb);
      ea = enc(qb[LAT-1], twos);
      eb = enc(qa[LAT-1], twos);
      push(a, b);
      if (ilv) begin
         @(negedge clk);
         #2;
         chk("R8 low phase", out_a, off_a ? '0 : ea);
         if (!off_b) chk("R8 low phase port B", out_b, eb);
      end
   endtask

   task automatic ramp_step(input string ta, input string tb);
      step(ta, tb, ramp_a, ramp_b);
      ramp_a = ramp_a + 14'd3;
      ramp_b = ramp_b - 14'd5;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired at %0t", $time);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; chan_a = '0; chan_b = '0;
      twos = 1'b0; route_q = 1'b1; ilv = 1'b0; off_a = 1'b0; off_b = 1'b0;
      model_reset();

      // R2: reset state
      repeat (3) @(posedge clk);
      #2;
      chk("R2 reset port A offset", out_a, MID);
      chk("R2 reset port B offset", out_b, MID);
      twos = 1'b1;
      #1;
      chk("R2 reset port A twos", out_a, '0);
      twos = 1'b0;

      // release and watch mid-scale drain out, then first word appear
      @(posedge clk);
      #2;
      rst_n = 1'b1;
      push(ramp_a, ramp_b);
      ramp_a = ramp_a + 14'd3;
      ramp_b = ramp_b - 14'd5;
      for (int i = 0; i < LAT - 1; i++) ramp_step("R2 drain A", "R2 drain B");
      ramp_step("R1 first A", "R1 first B");

      // table walk
      for (int v = 0; v < NVEC; v++) begin
         string base;
         twos    = VEC[v][4];
         ilv     = (VEC[v][3:2] == 2'd2);
         route_q = (VEC[v][3:2] != 2'd0);
         off_a   = VEC[v][1];
         off_b   = VEC[v][0];
         if (ilv)           base = "R8";
         else if (!route_q) base = twos ? "R7/R4" : "R7/R3";
         else               base = twos ? "R6/R4/R1" : "R6/R3/R1";
         for (int k = 0; k < 9; k++)
            ramp_step(off_a ? "R9" : base, off_b ? "R10" : base);
      end
      ilv = 1'b0; route_q = 1'b1; twos = 1'b0; off_a = 1'b0; off_b = 1'b0;

      // R5: format change seen in the same cycle
      @(posedge clk);
      #2;
      chk("R5 before change", out_a, qa[LAT-1]);
      twos = 1'b1;
      #1;
      chk("R5 after change", out_a, qa[LAT-1] ^ MID);
      chk("R5 after change port B", out_b, qb[LAT-1] ^ MID);
      push(ramp_a, ramp_b);

      // R4: extreme codes
      step("R4", "R4", 14'h0000, FULL);
      step("R4", "R4", FULL, 14'h0000);
      for (int i = 0; i < LAT - 2; i++) ramp_step("R4", "R4");
      step("R4 zero code", "R4 full code", MID, MID);
      step("R4 full code", "R4 zero code", MID, MID);
      twos = 1'b0;

      // R11: port disabled for a while, pipeline keeps flowing
      off_a = 1'b1;
      for (int i = 0; i < 4; i++) ramp_step("R9", "R9 port B unaffected");
      off_a = 1'b0;
      ramp_step("R11 port A", "R11 port B");
      off_b = 1'b1;
      for (int i = 0; i < 3; i++) ramp_step("R10 port A unaffected", "R10");
      off_b = 1'b0;
      ramp_step("R11 port A", "R11 port B");

      // R2: reset in mid-run clears the pipeline at once
      @(posedge clk);
      #2;
      rst_n = 1'b0;
      #1;
      chk("R2 mid-run reset A", out_a, MID);
      chk("R2 mid-run reset B", out_b, MID);
      model_reset();
      @(posedge clk);
      #2;
      rst_n = 1'b1;
      push(14'h0123, 14'h3210);
      for (int i = 0; i < LAT - 1; i++) ramp_step("R2 drain A", "R2 drain B");
      ramp_step("R1 after reset A", "R1 after reset B");

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule